// File: doc/BRIEF.md
# Power-On Reset and Output Gating Sequencer

This block brings the digital section of an audio converter out of power-up in an orderly way. A supply-good level comes from an analog threshold detector, modelled here as a plain digital input that goes high once the supply is above about 4 V. While supply-good is low, the block holds the converter's digital logic in reset. After supply-good rises, the block keeps that reset for a fixed count of system clocks. It then releases the reset but keeps forcing the serial output to zero, counting sample periods, until the decimation pipeline has had time to settle. Once that count is reached, it raises a data-valid flag and lifts the zero-force, both in the same cycle.

Sample periods are counted from a one-cycle strobe that the clock-control logic supplies. The system clock must already be running when the supply crosses the threshold, because supply-good passes through a short synchronizer and the reset counter is clocked by the system clock. The synchronizer needs at least as many edges as it has stages. A drop of supply-good at any moment forces reset at once, with no clock needed, and clears every counter and state, so the next rise starts the full sequence again.

The sequencer is a four-state machine. The states are:
- `PS_OFF`: supply low or not yet synchronized.
- `PS_HOLD`: counting system clocks with reset asserted.
- `PS_SETTLE`: reset released, output still zeroed, counting strobes.
- `PS_RUN`: output valid.

The transitions are:
- `PS_OFF`→`PS_HOLD` when the synchronized supply-good is seen.
- `PS_HOLD`→`PS_SETTLE` on the last clock of the hold count.
- `PS_SETTLE`→`PS_RUN` on the strobe that completes the settle count.
- Any state→`PS_OFF` asynchronously when supply-good falls.

Top module: `por_gate_seq`

## Requirements
- R1: `dig_rst` is 1 whenever `supply_ok` is 0, and it goes to 1 as soon as `supply_ok` falls, without waiting for a clock edge.
- R2: Count the rising clock edges from the first edge after `supply_ok` rises. `dig_rst` goes to 0 right after edge number RST_CLKS+SYNC_STAGES+1 and not before.
- R3: While `dig_rst` is 1, `zero_force` is 1 and `data_valid` is 0.
- R4: A `sample_tick` seen while `dig_rst` is 1, or on the edge that releases `dig_rst`, does not count toward the settle interval.
- R5: `data_valid` goes to 1, and `zero_force` goes to 0, at the edge that samples the SETTLE_SAMPLES-th `sample_tick` strictly after the release edge. Both change in that same cycle, and neither changes earlier.
- R6: Once `data_valid` is 1, it stays 1, and `zero_force` stays 0, until `supply_ok` falls.
- R7: A fall of `supply_ok` in any state restarts the whole sequence. After the next rise, the timings of R2 and R5 apply again in full.
- R8: Each clock cycle with `sample_tick` at 1 counts as one sample period, so a strobe every cycle advances the settle count on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| supply_ok | input | 1 | Supply-above-threshold indication; low acts as asynchronous reset |
| sample_tick | input | 1 | One-cycle strobe per sample period |
| dig_rst | output | 1 | Reset for the converter's digital section, active high |
| zero_force | output | 1 | Forces the serial transmitter's data to zero, active high |
| data_valid | output | 1 | Output data qualifier, high once settled |

## Verification
Every output is decoded straight from the state register, so each result appears in the cycle right after the edge that moves the state. The reset release is due RST_CLKS+SYNC_STAGES+1 edges after the supply rises, and validity is due on the edge of the SETTLE_SAMPLES-th strobe after that release. The bench numbers the edges from the supply rise, computes both edge numbers arithmetically from the strobe period and phase it drives, and compares all three outputs at every falling edge. For a supply drop, it samples one time step after the drop, with no clock edge in between, to show the reset acts asynchronously.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_HOLD   = 2'd1,
        PS_SETTLE = 2'd2,
        PS_RUN    = 2'd3
    } por_state_e;

    function automatic int unsigned larger_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic sync_out
);

    logic [STAGES-1:0] shift_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) shift_q <= 1'b0;
                else         shift_q <= 1'b1;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) shift_q <= '0;
                else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign sync_out = shift_q[STAGES-1];

endmodule

// File: rtl/por_counter.sv
module por_counter #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)   count <= '0;
        else if (clr)  count <= '0;
        else if (inc)  count <= count + 1'b1;
    end

endmodule

// File: rtl/por_fsm.sv
module por_fsm
    import por_seq_pkg::*;
#(
    parameter int unsigned RST_CLKS       = 1024,
    parameter int unsigned SETTLE_SAMPLES = 18436,
    parameter int unsigned CW             = 15
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          sync_ok,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          dig_rst,
    output logic          zero_force,
    output logic          data_valid
);

    localparam logic [CW-1:0] HOLD_LAST   = CW'(RST_CLKS - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_SAMPLES - 1);

    por_state_e state_q, state_d;

    // State register: the supply drop resets it without a clock.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= PS_OFF;
        else         state_q <= state_d;
    end

    // Transitions and counter control.
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            PS_OFF: begin
                if (sync_ok) begin
                    state_d = PS_HOLD;
                    cnt_clr = 1'b1;
                end
            end
            PS_HOLD: begin
                if (cnt == HOLD_LAST) begin
                    state_d = PS_SETTLE;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            PS_SETTLE: begin
                if (tick) begin
                    if (cnt == SETTLE_LAST) begin
                        state_d = PS_RUN;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            PS_RUN: begin
                state_d = PS_RUN;
            end
            default: begin
                state_d = PS_OFF;
            end
        endcase
    end

    // Moore outputs decoded from the state register.
    always_comb begin
        dig_rst    = 1'b1;
        zero_force = 1'b1;
        data_valid = 1'b0;
        unique case (state_q)
            PS_OFF, PS_HOLD: begin
                dig_rst    = 1'b1;
                zero_force = 1'b1;
                data_valid = 1'b0;
            end
            PS_SETTLE: begin
                dig_rst    = 1'b0;
                zero_force = 1'b1;
                data_valid = 1'b0;
            end
            PS_RUN: begin
                dig_rst    = 1'b0;
                zero_force = 1'b0;
                data_valid = 1'b1;
            end
            default: begin
                dig_rst    = 1'b1;
                zero_force = 1'b1;
                data_valid = 1'b0;
            end
        endcase
    end

    // R2
    hold_len_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(dig_rst) |-> $past(cnt) == HOLD_LAST);

    // R3
    rst_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
        dig_rst |-> (zero_force && !data_valid));

    // R5
    valid_on_tick_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(data_valid) |-> ($past(tick) && $past(cnt) == SETTLE_LAST));

    // R6
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
        data_valid |=> (data_valid && !zero_force));

    // R4
    settle_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == PS_SETTLE && !tick) |=> (state_q == PS_SETTLE && $stable(cnt)));

endmodule

// File: rtl/por_gate_seq.sv
module por_gate_seq
    import por_seq_pkg::*;
#(
    parameter int unsigned RST_CLKS       = 1024,
    parameter int unsigned SETTLE_SAMPLES = 18436,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic supply_ok,
    input  logic sample_tick,
    output logic dig_rst,
    output logic zero_force,
    output logic data_valid
);

    localparam int unsigned CNT_MAX = larger_of(RST_CLKS, SETTLE_SAMPLES);
    localparam int unsigned CW      = bits_for(CNT_MAX);

    logic          sync_ok;
    logic          cnt_clr;
    logic          cnt_inc;
    logic [CW-1:0] cnt;

    por_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .arst_n   (supply_ok),
        .sync_out (sync_ok)
    );

    por_counter #(
        .WIDTH (CW)
    ) u_cnt (
        .clk    (clk),
        .arst_n (supply_ok),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .count  (cnt)
    );

    por_fsm #(
        .RST_CLKS       (RST_CLKS),
        .SETTLE_SAMPLES (SETTLE_SAMPLES),
        .CW             (CW)
    ) u_fsm (
        .clk        (clk),
        .arst_n     (supply_ok),
        .sync_ok    (sync_ok),
        .tick       (sample_tick),
        .cnt        (cnt),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .dig_rst    (dig_rst),
        .zero_force (zero_force),
        .data_valid (data_valid)
    );

    // R1
    supply_rst_chk: assert property (@(posedge clk)
        !supply_ok |-> dig_rst);

endmodule

// File: tb/sim_por_gate_seq.sv
module sim_por_gate_seq;

    localparam time CLK_PERIOD = 10ns;
    localparam int  T_RST      = 8;
    localparam int  T_SETTLE   = 3;
    localparam int  T_SYNC     = 2;
    localparam int  REL_EDGE   = T_RST + T_SYNC + 1;
    localparam int  WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic supply_ok = 1'b0;
    logic sample_tick = 1'b0;
    logic dig_rst, zero_force, data_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    por_gate_seq #(
        .RST_CLKS       (T_RST),
        .SETTLE_SAMPLES (T_SETTLE),
        .SYNC_STAGES    (T_SYNC)
    ) u0 (
        .clk         (clk),
        .supply_ok   (supply_ok),
        .sample_tick (sample_tick),
        .dig_rst     (dig_rst),
        .zero_force  (zero_force),
        .data_valid  (data_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            report();
        end
    end

    function automatic bit strobe_at(int j, int per, int ph);
        return (j >= 1) && ((j % per) == ph);
    endfunction

    // Edge at which the settle count completes (R4, R5, R8).
    function automatic int valid_edge(int per, int ph);
        int n = 0;
        for (int j = REL_EDGE + 1; j < REL_EDGE + 1000; j++) begin
            if (strobe_at(j, per, ph)) n++;
            if (n == T_SETTLE) return j;
        end
        return -1;
    endfunction

    task automatic check_off();
        chk(dig_rst == 1'b1, "R1 dig_rst", int'(dig_rst), 1);
        chk(zero_force == 1'b1 && data_valid == 1'b0, "R3 zero/valid",
            int'({zero_force, data_valid}), 2);
    endtask

    // drop_at = 0 means no supply drop during the run.
    task automatic run_seq(input int per, input int ph, input int drop_at);
        int v;
        v = valid_edge(per, ph);
        supply_ok   = 1'b0;
        sample_tick = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check_off();
        end
        @(negedge clk);
        supply_ok   = 1'b1;
        sample_tick = strobe_at(1, per, ph);
        for (int k = 1; k <= v + 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(dig_rst == (k < REL_EDGE), "R2 dig_rst release", int'(dig_rst),
                int'(k < REL_EDGE));
            if (k < REL_EDGE)
                chk(zero_force && !data_valid, "R3 gated in reset",
                    int'({zero_force, data_valid}), 2);
            chk(data_valid == (k >= v), "R5 R4 R8 data_valid edge", int'(data_valid),
                int'(k >= v));
            chk(zero_force == (k < v), "R5 zero_force edge", int'(zero_force),
                int'(k < v));
            if (k > v)
                chk(data_valid && !zero_force, "R6 valid held",
                    int'({data_valid, zero_force}), 2);
            if (drop_at != 0 && k == drop_at) begin
                supply_ok   = 1'b0;
                sample_tick = 1'b0;
                #1;
                chk(dig_rst == 1'b1, "R1 R7 async reset on drop", int'(dig_rst), 1);
                chk(zero_force && !data_valid, "R7 output gated on drop",
                    int'({zero_force, data_valid}), 2);
                return;
            end
            sample_tick = strobe_at(k + 1, per, ph);
        end
    endtask

    initial begin
        // Reset state with supply low.
        repeat (2) @(negedge clk);
        check_off();

        // Sweep strobe period and phase (R2, R4, R5, R6, R8).
        for (int per = 1; per <= 6; per++)
            for (int ph = 0; ph < per; ph++)
                run_seq(per, ph, 0);

        // Drop supply at every point of the sequence, then a full run (R7).
        for (int d = 1; d <= valid_edge(2, 1) + 2; d++) begin
            run_seq(2, 1, d);
            run_seq(3, 2, 0);
        end

        report();
    end

endmodule